// File: doc/BRIEF.md
# Serial IRQ Request Generator

This block keeps two interrupt request flags that software sets and clears through a small register port. It shows each pending flag on a shared serial interrupt line, one in frame slot 1 and one in frame slot 12. Either flag can instead be tied to a status input from the host interface, such as an output-buffer-full flag. A per-flag enable bit in a control register makes that tie.

The serial side runs in continuous mode and repeats the same cycle without pause. First comes a start frame, in which the line is driven low for 4 clocks. Sixteen data frames of 3 clocks each follow, with the phases sample, recovery and turnaround. A stop frame of 2 clocks with the line released ends the cycle, so one cycle lasts 54 clocks. A slot's request is captured once, on the clock edge that enters that slot's sample phase. A change in the middle of a frame is therefore never shown as a partial pulse.

The register port is plain control: an address, write data, a write strobe and combinational read data. It has no handshake or back-pressure, so every write is taken in the cycle in which its strobe is high.

Top module: `sirq_gen`

## Requirements
- R1: After reset the request register (address 0) and the control register (address 1) both read 0x00, and the sequencer is in the start frame with `sirq_oe`=1 and `sirq_o`=0.
- R2: Bits 7:2 of both registers ignore writes and read 0. Addresses 2 and 3 read 0x00.
- R3: Bit 0 of the control register enables the tie of IRQ1 (request bit 0) to `obf_a`. Bit 1 enables the tie of IRQ12 (request bit 1) to `obf_b`. While its enable is 0, a request bit takes the written value on a write to address 0, keeps its value otherwise, and ignores its status input.
- R4: While its enable is 1, a request bit copies its status input one clock later, and writes to it have no effect. In particular, a write of 0 cannot clear it while the status input is 1.
- R5: The start frame drives the line low (`sirq_oe`=1, `sirq_o`=0) for 4 clocks at the beginning of every cycle.
- R6: In its slot's recovery phase, a pending request drives the line high (`sirq_oe`=1, `sirq_o`=1). Turnaround phases release the line.
- R7: Frames other than 1 and 12, and slots with no pending request, keep the line released. A released line has `sirq_oe`=0 and `sirq_o`=1. Each cycle ends with a 2-clock stop frame in which the line is released, so a cycle is 54 clocks.
- R8: A slot's request is the value the request bit held in the clock just before that slot's sample phase. When the request is pending, the sample phase drives the line low, and the captured value holds for the whole frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register address: 0 = requests, 1 = control |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle it is high |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| obf_a | input | 1 | Status flag tied to IRQ1 |
| obf_b | input | 1 | Status flag tied to IRQ12 |
| sirq_o | output | 1 | Serial interrupt line value |
| sirq_oe | output | 1 | Serial interrupt line drive enable |

## Verification
Register writes and status copies appear in the read data one clock after the edge that takes them. The serial line position is a pure function of the number of clock edges since reset was released, taken modulo 54. The slot value appears one edge after it is captured: the bench latches the request state of its model at the edge that enters the slot's sample phase and expects it on the line from then on. All outputs are compared at the falling edge, after that cycle's inputs are driven. The model is updated only at the rising edge, so every comparison sees exactly the registers the design holds at that point.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  typedef enum logic [1:0] {
    SEQ_START = 2'd0,
    SEQ_DATA  = 2'd1,
    SEQ_STOP  = 2'd2
  } seq_st_e;

  typedef enum logic [1:0] {
    PH_SAMPLE  = 2'd0,
    PH_RECOVER = 2'd1,
    PH_TURN    = 2'd2
  } phase_e;

  localparam int unsigned REG_REQ = 0;
  localparam int unsigned REG_CTL = 1;
endpackage

// File: rtl/sirq_regs.sv
module sirq_regs #(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 2,
  parameter int unsigned DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic           we,
  input  logic [NCH-1:0] status,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] req
);
  import sirq_pkg::*;

  logic [NCH-1:0] req_q;
  logic [NCH-1:0] ctl_q;
  logic           wr_req;
  logic           wr_ctl;

  assign wr_req = we && (addr == AW'(REG_REQ));
  assign wr_ctl = we && (addr == AW'(REG_CTL));

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else if (wr_ctl) ctl_q <= wdata[NCH-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)        req_q[i] <= 1'b0;
      else if (ctl_q[i]) req_q[i] <= status[i];
      else if (wr_req)   req_q[i] <= wdata[i];
    end

    AST_SYNC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl_q[i]) |-> (req_q[i] == $past(status[i]))); // R4
    AST_PLAIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_req && !ctl_q[i]) |-> (req_q[i] == $past(wdata[i]))); // R3
    AST_PLAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!wr_req && !ctl_q[i]) |-> $stable(req_q[i])); // R3
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(REG_REQ))      rdata[NCH-1:0] = req_q;
    else if (addr == AW'(REG_CTL)) rdata[NCH-1:0] = ctl_q;
  end

  if (NCH < DW) begin : g_rsvd
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[DW-1:NCH] == '0); // R2
  end

  assign req = req_q;
endmodule

// File: rtl/sirq_seq.sv
module sirq_seq #(
  parameter int unsigned NFR       = 16,
  parameter int unsigned START_LEN = 4,
  parameter int unsigned STOP_LEN  = 2,
  localparam int unsigned FW = $clog2(NFR),
  localparam int unsigned CW = $clog2(START_LEN + STOP_LEN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output sirq_pkg::seq_st_e      st_o,
  output sirq_pkg::phase_e       phase_o,
  output logic [FW-1:0]          frame_o,
  output logic                   load_o,
  output logic [FW-1:0]          nxt_frame_o
);
  import sirq_pkg::*;

  seq_st_e       st_q;
  phase_e        ph_q;
  logic [FW-1:0] fr_q;
  logic [CW-1:0] cnt_q;
  logic          start_last;
  logic          stop_last;
  logic          frame_last;

  assign start_last = (st_q == SEQ_START) && (cnt_q == CW'(START_LEN - 1));
  assign stop_last  = (st_q == SEQ_STOP)  && (cnt_q == CW'(STOP_LEN - 1));
  assign frame_last = (fr_q == FW'(NFR - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SEQ_START;
      ph_q  <= PH_SAMPLE;
      fr_q  <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        SEQ_START: begin
          if (start_last) begin
            st_q  <= SEQ_DATA;
            fr_q  <= '0;
            ph_q  <= PH_SAMPLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_DATA: begin
          unique case (ph_q)
            PH_SAMPLE:  ph_q <= PH_RECOVER;
            PH_RECOVER: ph_q <= PH_TURN;
            default: begin
              ph_q <= PH_SAMPLE;
              if (frame_last) begin
                st_q  <= SEQ_STOP;
                cnt_q <= '0;
              end else begin
                fr_q <= fr_q + 1'b1;
              end
            end
          endcase
        end
        default: begin
          if (stop_last) begin
            st_q  <= SEQ_START;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign load_o      = start_last ||
                       ((st_q == SEQ_DATA) && (ph_q == PH_TURN) && !frame_last);
  assign nxt_frame_o = (st_q == SEQ_START) ? '0 : fr_q + 1'b1;
  assign st_o        = st_q;
  assign phase_o     = ph_q;
  assign frame_o     = fr_q;

  AST_STOP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == SEQ_STOP && st_q == SEQ_DATA) |-> 1'b0); // R7
  AST_DATA_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == SEQ_START && st_q == SEQ_DATA) |-> (fr_q == '0 && ph_q == PH_SAMPLE)); // R5
endmodule

// File: rtl/sirq_slot.sv
module sirq_slot #(
  parameter int unsigned NCH = 2,
  parameter int unsigned NFR = 16,
  localparam int unsigned FW = $clog2(NFR),
  parameter logic [NCH*FW-1:0] SLOTS = {4'd12, 4'd1}
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           load,
  input  logic [FW-1:0]  nxt_frame,
  output logic           pend_o
);
  logic [NCH-1:0] hit;

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign hit[i] = req[i] && (nxt_frame == SLOTS[i*FW +: FW]);
  end

  logic pend_q;
  always_ff @(posedge clk) begin
    if (!rst_n)    pend_q <= 1'b0;
    else if (load) pend_q <= |hit;
  end
  assign pend_o = pend_q;

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!load) |-> $stable(pend_q)); // R8
  AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> (pend_q == $past(|hit))); // R8
endmodule

// File: rtl/sirq_gen.sv
module sirq_gen #(
  parameter int unsigned AW        = 2,
  parameter int unsigned DW        = 8,
  parameter int unsigned NFR       = 16,
  parameter int unsigned START_LEN = 4,
  parameter int unsigned STOP_LEN  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_we,
  output logic [DW-1:0] reg_rdata,
  input  logic          obf_a,
  input  logic          obf_b,
  output logic          sirq_o,
  output logic          sirq_oe
);
  import sirq_pkg::*;

  localparam int unsigned NCH = 2;
  localparam int unsigned FW  = $clog2(NFR);

  logic [NCH-1:0] req;
  seq_st_e        st;
  phase_e         phase;
  logic [FW-1:0]  frame;
  logic           load;
  logic [FW-1:0]  nxt_frame;
  logic           pend;

  sirq_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
    .status({obf_b, obf_a}), .rdata(reg_rdata), .req(req)
  );

  sirq_seq #(.NFR(NFR), .START_LEN(START_LEN), .STOP_LEN(STOP_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .st_o(st), .phase_o(phase), .frame_o(frame),
    .load_o(load), .nxt_frame_o(nxt_frame)
  );

  sirq_slot #(.NCH(NCH), .NFR(NFR), .SLOTS({FW'(12), FW'(1)})) u_slot (
    .clk(clk), .rst_n(rst_n), .req(req), .load(load), .nxt_frame(nxt_frame),
    .pend_o(pend)
  );

  logic frame_unused;
  assign frame_unused = ^frame;

  always_comb begin
    sirq_oe = 1'b0;
    sirq_o  = 1'b1;
    unique case (st)
      SEQ_START: begin
        sirq_oe = 1'b1;
        sirq_o  = 1'b0;
      end
      SEQ_DATA: begin
        if (pend && phase == PH_SAMPLE) begin
          sirq_oe = 1'b1;
          sirq_o  = 1'b0;
        end else if (pend && phase == PH_RECOVER) begin
          sirq_oe = 1'b1;
          sirq_o  = 1'b1;
        end
      end
      default: ;
    endcase
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SEQ_START) |-> (sirq_oe && !sirq_o)); // R5
  AST_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == SEQ_STOP) || (st == SEQ_DATA && phase == PH_TURN)) |-> !sirq_oe); // R7
  AST_RECOVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SEQ_DATA && phase == PH_RECOVER && sirq_oe) |-> sirq_o); // R6
  AST_SAMPLE_FROM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SEQ_DATA && phase == PH_SAMPLE && sirq_oe) |-> (frame == FW'(1) || frame == FW'(12))); // R8
endmodule

// File: tb/sirq_gen_bench.sv
module sirq_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic       obf_a = 1'b0;
  logic       obf_b = 1'b0;
  logic       sirq_o;
  logic       sirq_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // bench model
  logic [1:0] m_req = '0;
  logic [1:0] m_ctl = '0;
  int         m_pos = 0;
  logic       m_pend = 1'b0;

  always #4 clk = ~clk;

  sirq_gen u_sirq_gen (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .obf_a(obf_a), .obf_b(obf_b),
    .sirq_o(sirq_o), .sirq_oe(sirq_oe)
  );

  function automatic logic [7:0] exp_rdata(input logic [1:0] a);
    if (a == 2'd0) return {6'b0, m_req};
    if (a == 2'd1) return {6'b0, m_ctl};
    return 8'h00;
  endfunction

  // {oe, o}
  function automatic logic [1:0] exp_line(input int p, input logic pd);
    int f, ph;
    if (p < 4) return 2'b10;
    if (p >= 52) return 2'b01;
    f  = (p - 4) / 3;
    ph = (p - 4) % 3;
    if (ph == 0 && pd) return 2'b10;
    if (ph == 1 && pd) return 2'b11;
    return 2'b01;
  endfunction

  function automatic string line_tag(input int p, input logic pd);
    int ph;
    if (p < 4) return "R5";
    if (p >= 52) return "R7";
    ph = (p - 4) % 3;
    if (!pd) return "R7";
    if (ph == 0) return "R8";
    return "R6";
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h pos=%0d", tag, act, exp, m_pos);
    end
  endtask

  task automatic check_now();
    string t;
    t = (reg_addr >= 2) ? "R2" : ((reg_addr == 1) ? "R3" : (m_ctl != 0 ? "R4" : "R3"));
    check(t, reg_rdata, exp_rdata(reg_addr));
    check(line_tag(m_pos, m_pend), {6'b0, sirq_oe, sirq_o}, {6'b0, exp_line(m_pos, m_pend)});
  endtask

  // advance one clock, updating the model from the inputs now applied
  task automatic step();
    logic [1:0] nreq, nctl, st;
    int         npos;
    logic       npend;
    st   = {obf_b, obf_a};
    nctl = (reg_we && reg_addr == 2'd1) ? reg_wdata[1:0] : m_ctl;
    for (int i = 0; i < 2; i++) begin
      if (m_ctl[i])                        nreq[i] = st[i];
      else if (reg_we && reg_addr == 2'd0) nreq[i] = reg_wdata[i];
      else                                 nreq[i] = m_req[i];
    end
    npos  = (m_pos + 1) % 54;
    npend = m_pend;
    if (npos >= 4 && npos < 52 && ((npos - 4) % 3) == 0) begin
      if ((npos - 4) / 3 == 1)       npend = m_req[0];
      else if ((npos - 4) / 3 == 12) npend = m_req[1];
      else                           npend = 1'b0;
    end
    @(posedge clk);
    m_req = nreq; m_ctl = nctl; m_pos = npos; m_pend = npend;
    @(negedge clk);
  endtask

  task automatic drive(input logic we, input logic [1:0] a, input logic [7:0] d,
                       input logic sa, input logic sb);
    reg_we = we; reg_addr = a; reg_wdata = d; obf_a = sa; obf_b = sb;
    #1;
    check_now();
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    drive(0, 2'd0, 8'h00, 0, 0);
    check("R1", reg_rdata, 8'h00);
    drive(0, 2'd1, 8'h00, 0, 0);
    check("R1", {6'b0, sirq_oe, sirq_o}, 8'h02);
    // R2 reserved bits: write all ones, read back masked
    drive(1, 2'd0, 8'hFF, 0, 0); step();
    drive(0, 2'd0, 8'h00, 0, 0);
    check("R2", reg_rdata, 8'h03);
    drive(1, 2'd2, 8'hFF, 0, 0); step();
    drive(0, 2'd2, 8'h00, 0, 0); step();
    // R3 status ignored while sync off, clear by write
    drive(1, 2'd0, 8'h00, 1, 1); step();
    drive(0, 2'd0, 8'h00, 1, 1); step();
    check("R3", reg_rdata, 8'h00);
    // R4 sync on: write 0 cannot clear while status high
    drive(1, 2'd1, 8'h03, 1, 1); step();
    drive(0, 2'd0, 8'h00, 1, 1); step();
    drive(1, 2'd0, 8'h00, 1, 1); step();
    drive(0, 2'd0, 8'h00, 1, 1);
    check("R4", reg_rdata, 8'h03);
    step();
    drive(1, 2'd1, 8'h00, 0, 0); step();
    // random phase with full line checking
    for (int n = 0; n < 4000; n++) begin
      logic       we;
      logic [1:0] a;
      logic       sa, sb;
      we = ($urandom_range(0, 9) == 0);
      a  = 2'($urandom_range(0, 3));
      sa = ($urandom_range(0, 7) == 0) ? ~obf_a : obf_a;
      sb = ($urandom_range(0, 7) == 0) ? ~obf_b : obf_b;
      drive(we, a, 8'($urandom), sa, sb);
      step();
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule